// File: doc/BRIEF.md
# SPI Slave Register Bridge with Burst

This block is a four-wire SPI slave that reaches a byte-wide register space with a 13-bit address. The register storage sits outside the block. The bridge issues single-cycle requests to that storage, and the storage returns read data on a fixed schedule. The bridge samples the serial pins in its own system clock domain. Clock polarity, clock phase and field bit order come from static configuration inputs. The SPI master always drives the clock.

Each access opens with a two-byte control word. On the wire the control word carries, in this order: a direction flag (1 = read), the address, one reserved bit and a burst flag. One data byte follows the control word. With chip select held low, a burst access keeps sending data bytes at consecutive addresses. A non-burst access expects a fresh control word after its data byte. Raising chip select ends any access. The first byte after chip select falls again is always a control byte.

The sequencer has four states:
- `ST_IDLE`: chip select is high.
- `ST_CTRL`: the control bits are being collected.
- `ST_RDATA`: a read data byte is being exchanged.
- `ST_WDATA`: a write data byte is being exchanged.

The transitions are:
- `ST_IDLE`→`ST_CTRL` when chip select falls.
- `ST_CTRL`→`ST_RDATA` or `ST_WDATA` on the last control bit, chosen by the direction flag.
- `ST_RDATA` or `ST_WDATA`→`ST_CTRL` at the end of a non-burst data byte.
- `ST_RDATA` or `ST_WDATA` back to itself at the end of a burst data byte.
- Any state→`ST_IDLE` whenever chip select is high.

Top module: `spi_reg_bridge`

## Requirements
- R1: The bridge works in all four clock modes. Data is sampled on the rising SCLK edge when `cfg_cpol == cfg_cpha`, and on the falling edge otherwise. MISO changes on the opposite edge.
- R2: The control word is 16 bits in wire order: the direction flag (1 = read), the 13 address bits, one reserved bit, then the burst flag. The position of the direction flag and the burst flag never depends on `cfg_swap`.
- R3: With `cfg_swap` = 0, the address and data fields travel MSB first. With `cfg_swap` = 1, they travel LSB first. This applies to MOSI and to MISO.
- R4: At the end of every write data byte, exactly one single-cycle write request is issued, carrying the current address and the byte. After a non-burst access with chip select held low, the next byte is decoded as a control word.
- R5: A read request is issued once the control word of a read completes. The byte returned on `rsp_rdata` one clock after the request is shifted out on MISO during the following data byte. MISO is 0 during control bytes, during write data bytes and while deselected.
- R6: In a burst, each further data byte uses the previous address plus one. The address wraps from 0x1FFF to 0x0000.
- R7: Chip select high ends any burst. A partly received byte is discarded and causes no request. The next byte after chip select falls is decoded as control.
- R8: At the end of each burst read data byte, a read request is issued for the next address, so that its data is ready for the next byte.
- R9: After reset, MISO is 0 and no request is issued until a complete control word has been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Idle level of SCLK |
| cfg_cpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| cfg_swap | input | 1 | 0: address and data MSB first; 1: LSB first |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| req_valid | output | 1 | Single-cycle register request strobe |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | ADDR_W | Register address of the request |
| req_wdata | output | 8 | Write data of the request |
| rsp_rdata | input | 8 | Read data from storage, valid one cycle after a read request |

## Verification
The bench builds the bridge with its defaults: a 13-bit address and a two-stage pin synchronizer. The 13-bit address makes the 0x1FFF to 0x0000 burst wrap reachable in a three-byte burst. The two-stage synchronizer, combined with an SCLK half period of eight system clocks, gives read data time to arrive before its first MISO bit is due. Stimulus covers:
- all four clock modes;
- both bit orders;
- several accesses inside one chip-select frame;
- a burst cut short by chip select;
- a truncated data byte.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CTRL  = 2'd1,
        ST_RDATA = 2'd2,
        ST_WDATA = 2'd3
    } br_state_t;

    function automatic logic [7:0] flip8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = v[7-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                chain[i] <= chain[i-1];
            end
            chain[0] <= d_in;
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/spi_bridge_edge.sv
module spi_bridge_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cpol,
    input  logic cpha,
    output logic smp,
    output logic shf
);

    logic sclk_d;
    logic rise;
    logic fall;
    logic smp_on_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
        end
    end

    assign rise        = sclk_s & ~sclk_d;
    assign fall        = ~sclk_s & sclk_d;
    assign smp_on_rise = (cpol == cpha);
    assign smp         = smp_on_rise ? rise : fall;
    assign shf         = smp_on_rise ? fall : rise;

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
    import spi_bridge_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_swap,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_wdata,
    input  logic [7:0]        rsp_rdata
);

    localparam int CTRL_LEN = ((ADDR_W + 2 + 7) / 8) * 8;
    localparam int CNT_W    = $clog2(CTRL_LEN);
    localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_LEN - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(7);

    logic [2:0] pin_s;
    logic       cs_s;
    logic       sclk_s;
    logic       mosi_s;
    logic       smp;
    logic       shf;

    spi_bridge_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({spi_cs_n, spi_sclk, spi_mosi}),
        .d_out(pin_s)
    );

    assign cs_s   = pin_s[2];
    assign sclk_s = pin_s[1];
    assign mosi_s = pin_s[0];

    spi_bridge_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk_s(sclk_s),
        .cpol  (cfg_cpol),
        .cpha  (cfg_cpha),
        .smp   (smp),
        .shf   (shf)
    );

    br_state_t           state;
    br_state_t           state_nx;
    logic [CNT_W-1:0]    bit_cnt;
    logic [CTRL_LEN-2:0] rx_sr;
    logic [CTRL_LEN-1:0] rx_nx;
    logic [ADDR_W-1:0]   addr_q;
    logic [ADDR_W-1:0]   addr_raw;
    logic [ADDR_W-1:0]   addr_dec;
    logic [ADDR_W-1:0]   addr_inc;
    logic                burst_q;
    logic [7:0]          rd_byte;
    logic                rd_stage;
    logic                miso_q;
    logic                ctrl_done;
    logic                byte_done;
    logic                ctl_rw;
    logic                ctl_burst;
    logic [7:0]          data_nx;
    logic [2:0]          tx_idx;

    // Serial word as it would look after the current sample.
    assign rx_nx     = {rx_sr, mosi_s};
    assign ctl_rw    = rx_nx[CTRL_LEN-1];
    assign ctl_burst = rx_nx[0];
    assign addr_raw  = rx_nx[CTRL_LEN-2 -: ADDR_W];
    assign data_nx   = cfg_swap ? flip8(rx_nx[7:0]) : rx_nx[7:0];
    assign addr_inc  = addr_q + 1'b1;
    assign tx_idx    = cfg_swap ? bit_cnt[2:0] : (3'd7 - bit_cnt[2:0]);

    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            addr_dec[i] = cfg_swap ? addr_raw[ADDR_W-1-i] : addr_raw[i];
        end
    end

    assign ctrl_done = (state == ST_CTRL) && smp && !cs_s && (bit_cnt == CTRL_LAST);
    assign byte_done = ((state == ST_RDATA) || (state == ST_WDATA)) && smp && !cs_s
                       && (bit_cnt == BYTE_LAST);

    // Next-state decode.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!cs_s) state_nx = ST_CTRL;
            end
            ST_CTRL: begin
                if (cs_s)           state_nx = ST_IDLE;
                else if (ctrl_done) state_nx = ctl_rw ? ST_RDATA : ST_WDATA;
            end
            ST_RDATA, ST_WDATA: begin
                if (cs_s)                       state_nx = ST_IDLE;
                else if (byte_done && !burst_q) state_nx = ST_CTRL;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            addr_q    <= '0;
            burst_q   <= 1'b0;
            rd_byte   <= '0;
            rd_stage  <= 1'b0;
            miso_q    <= 1'b0;
            req_valid <= 1'b0;
            req_write <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            req_valid <= 1'b0;
            rd_stage  <= req_valid && !req_write;
            if (rd_stage) rd_byte <= rsp_rdata;

            if ((state == ST_IDLE) || cs_s) begin
                bit_cnt <= '0;
                miso_q  <= 1'b0;
            end else begin
                if (smp) begin
                    rx_sr   <= rx_nx[CTRL_LEN-2:0];
                    bit_cnt <= (ctrl_done || byte_done) ? '0 : bit_cnt + 1'b1;
                end
                if (shf) begin
                    miso_q <= (state == ST_RDATA) ? rd_byte[tx_idx] : 1'b0;
                end
                if (ctrl_done) begin
                    addr_q  <= addr_dec;
                    burst_q <= ctl_burst;
                    if (ctl_rw) begin
                        req_valid <= 1'b1;
                        req_write <= 1'b0;
                        req_addr  <= addr_dec;
                    end
                end
                if (byte_done && (state == ST_WDATA)) begin
                    req_valid <= 1'b1;
                    req_write <= 1'b1;
                    req_addr  <= addr_q;
                    req_wdata <= data_nx;
                    if (burst_q) addr_q <= addr_inc;
                end
                if (byte_done && (state == ST_RDATA) && burst_q) begin
                    addr_q    <= addr_inc;
                    req_valid <= 1'b1;
                    req_write <= 1'b0;
                    req_addr  <= addr_inc;
                end
            end
        end
    end

    assign spi_miso = miso_q;

endmodule

// File: rtl/spi_reg_bridge_chk.sv
module spi_reg_bridge_chk
    import spi_bridge_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input br_state_t         state,
    input logic              shf,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              spi_miso
);

    logic              wr_run;
    logic              rd_run;
    logic [ADDR_W-1:0] wr_last;
    logic [ADDR_W-1:0] rd_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_run  <= 1'b0;
            rd_run  <= 1'b0;
            wr_last <= '0;
            rd_last <= '0;
        end else begin
            if (state != ST_WDATA) begin
                wr_run <= 1'b0;
            end else if (req_valid && req_write) begin
                wr_run  <= 1'b1;
                wr_last <= req_addr;
            end
            if (state != ST_RDATA) begin
                rd_run <= 1'b0;
            end else if (req_valid && !req_write) begin
                rd_run  <= 1'b1;
                rd_last <= req_addr;
            end
        end
    end

    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !req_valid);

    a_r9_miso_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !spi_miso);

    a_r5_miso_low_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && shf) |=> !spi_miso);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    a_r2_read_enters_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> (state == ST_RDATA));

    a_r6_write_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && wr_run) |-> (req_addr == ADDR_W'(wr_last + 1'b1)));

    a_r8_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && rd_run) |-> (req_addr == ADDR_W'(rd_last + 1'b1)));

endmodule

bind spi_reg_bridge spi_reg_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .shf      (shf),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .spi_miso (spi_miso)
);

// File: tb/spi_reg_bridge_bench.sv
module spi_reg_bridge_bench;

    localparam int AW   = 13;
    localparam int HALF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpol = 1'b0, cpha = 1'b0, swap = 1'b0;
    logic          sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic          miso;
    logic          req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [7:0]    req_wdata;
    logic [7:0]    rsp_rdata = 8'h00;

    always #5 clk = ~clk;

    spi_reg_bridge u_spi_reg_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_swap(swap),
        .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        string         tag;
    } item_t;
    item_t exp_q[$];

    function automatic logic [7:0] rdval(logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A ^ {a[12:8], 3'b000};
    endfunction

    function automatic logic [7:0] rev8(logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic logic [AW-1:0] rev13(logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
        return r;
    endfunction

    // Storage model: read data valid the cycle after the request.
    always @(posedge clk) begin
        if (req_valid && !req_write) rsp_rdata <= rdval(req_addr);
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(logic we, logic [AW-1:0] a, logic [7:0] d, string tag);
        item_t it;
        it.we = we; it.addr = a; it.data = d; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: pops expected requests as the design issues them.
    always @(negedge clk) begin
        item_t e;
        if (rst_n && req_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R7 R9: unexpected request actual we=%0b addr=%0h, expected none",
                         req_write, req_addr);
            end else begin
                e = exp_q.pop_front();
                check({e.tag, " request kind"}, 32'(req_write), 32'(e.we));
                check({e.tag, " request address"}, 32'(req_addr), 32'(e.addr));
                if (e.we) check({e.tag, " request data"}, 32'(req_wdata), 32'(e.data));
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(logic p, logic h, logic s);
        cpol = p; cpha = h; swap = s; sclk = p;
        wait_clk(2 * HALF);
    endtask

    task automatic cs_fall();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_rise();
        wait_clk(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(2 * HALF);
    endtask

    // Exchange nb bits; tx[7] goes first, rx[7] is the first bit received.
    task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            if (!cpha) begin
                mosi = tx[i];
                wait_clk(HALF);
                rx[i] = miso;
                sclk = ~cpol;
                wait_clk(HALF);
                sclk = cpol;
            end else begin
                sclk = ~cpol;
                mosi = tx[i];
                wait_clk(HALF);
                rx[i] = miso;
                sclk = cpol;
                wait_clk(HALF);
            end
        end
    endtask

    task automatic send_ctrl(logic rw, logic [AW-1:0] a, logic burst, string tag);
        logic [15:0] w;
        logic [7:0]  r0, r1;
        w = {rw, (swap ? rev13(a) : a), 1'b0, burst};
        if (rw) push(1'b0, a, 8'h00, tag);
        xfer(w[15:8], 8, r0);
        xfer(w[7:0], 8, r1);
        check({tag, " R5 MISO low in control"}, 32'({r0, r1}), 32'h0);
    endtask

    task automatic wr_data(logic [AW-1:0] a, logic [7:0] d, string tag);
        logic [7:0] r;
        push(1'b1, a, d, tag);
        xfer(swap ? rev8(d) : d, 8, r);
        check({tag, " R5 MISO low in write data"}, 32'(r), 32'h0);
    endtask

    task automatic rd_data(logic [AW-1:0] a, logic more, string tag);
        logic [7:0] r;
        logic [7:0] got;
        if (more) push(1'b0, AW'(a + 1'b1), 8'h00, {tag, " R8 prefetch"});
        xfer(8'h00, 8, r);
        got = swap ? rev8(r) : r;
        check({tag, " R5 read data"}, 32'(got), 32'(rdval(a)));
    endtask

    task automatic run();
        logic [7:0] junk;
        // R9: reset state
        wait_clk(5);
        check("R9 MISO in reset", 32'(miso), 32'h0);
        check("R9 no request in reset", 32'(req_valid), 32'h0);
        rst_n = 1'b1;
        wait_clk(2 * HALF);
        check("R9 MISO after reset", 32'(miso), 32'h0);

        // R1: every clock mode, single write
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0], 1'b0);
            cs_fall();
            send_ctrl(1'b0, AW'(13'h0A5C + m), 1'b0, "R1");
            wr_data(AW'(13'h0A5C + m), 8'(8'h3C ^ m), "R1");
            cs_rise();
        end

        // R5: single reads, both phases
        set_mode(1'b0, 1'b0, 1'b0);
        cs_fall();
        send_ctrl(1'b1, 13'h0123, 1'b0, "R5");
        rd_data(13'h0123, 1'b0, "R5");
        cs_rise();
        set_mode(1'b1, 1'b1, 1'b0);
        cs_fall();
        send_ctrl(1'b1, 13'h1ABC, 1'b0, "R5");
        rd_data(13'h1ABC, 1'b0, "R5");
        cs_rise();

        // R2 R3: LSB-first fields, flags stay in place
        set_mode(1'b1, 1'b1, 1'b1);
        cs_fall();
        send_ctrl(1'b0, 13'h1001, 1'b0, "R2 R3");
        wr_data(13'h1001, 8'h81, "R2 R3");
        cs_rise();
        set_mode(1'b0, 1'b1, 1'b1);
        cs_fall();
        send_ctrl(1'b1, 13'h0F0E, 1'b0, "R3");
        rd_data(13'h0F0E, 1'b0, "R3");
        cs_rise();

        // R4: two non-burst accesses in one frame
        set_mode(1'b0, 1'b1, 1'b0);
        cs_fall();
        send_ctrl(1'b0, 13'h0040, 1'b0, "R4");
        wr_data(13'h0040, 8'h5A, "R4");
        send_ctrl(1'b1, 13'h0041, 1'b0, "R4");
        rd_data(13'h0041, 1'b0, "R4");
        cs_rise();
        set_mode(1'b1, 1'b0, 1'b0);
        cs_fall();
        send_ctrl(1'b0, 13'h0042, 1'b0, "R4");
        wr_data(13'h0042, 8'hE7, "R4");
        send_ctrl(1'b0, 13'h0999, 1'b0, "R4");
        wr_data(13'h0999, 8'h18, "R4");
        cs_rise();

        // R6: burst write across the top of the address space
        set_mode(1'b0, 1'b0, 1'b0);
        cs_fall();
        send_ctrl(1'b0, 13'h1FFE, 1'b1, "R6");
        wr_data(13'h1FFE, 8'h11, "R6");
        wr_data(13'h1FFF, 8'h22, "R6");
        wr_data(13'h0000, 8'h33, "R6");
        cs_rise();

        // R8: burst read with prefetch of the next address
        set_mode(1'b1, 1'b0, 1'b0);
        cs_fall();
        send_ctrl(1'b1, 13'h0200, 1'b1, "R8");
        rd_data(13'h0200, 1'b1, "R8");
        rd_data(13'h0201, 1'b1, "R8");
        rd_data(13'h0202, 1'b1, "R8");
        cs_rise();

        // R7: chip select ends a burst; the next byte is control
        set_mode(1'b0, 1'b1, 1'b0);
        cs_fall();
        send_ctrl(1'b0, 13'h0300, 1'b1, "R7");
        wr_data(13'h0300, 8'hAA, "R7");
        wr_data(13'h0301, 8'hBB, "R7");
        cs_rise();
        cs_fall();
        send_ctrl(1'b0, 13'h0777, 1'b0, "R7");
        wr_data(13'h0777, 8'hCC, "R7");
        cs_rise();

        // R7: a truncated data byte issues nothing
        cs_fall();
        send_ctrl(1'b0, 13'h0055, 1'b0, "R7");
        xfer(8'hF0, 5, junk);
        cs_rise();
        wait_clk(4 * HALF);
        check("R7 no request from partial byte", 32'(exp_q.size()), 32'h0);
        cs_fall();
        send_ctrl(1'b0, 13'h0056, 1'b0, "R7");
        wr_data(13'h0056, 8'h96, "R7");
        cs_rise();

        wait_clk(4 * HALF);
        check("R4 R8 all expected requests seen", 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout, expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule